// File: doc/BRIEF.md
# Instrument Status Byte with Service Request

This block keeps the top-level status byte of an instrument's reporting hierarchy. Lower-level status logic supplies one-bit summaries: the error queue holds an entry, a message is ready to read, the questionable, event-status and operation summaries, and two spare inputs. The block registers these into an 8-bit byte and derives bit 6, the master summary, as the OR of every other bit gated by an 8-bit enable mask. The enable mask is written and read back through a plain register port.

When any enabled bit other than bit 6 goes from 0 to 1, the block raises a sticky service-request output. That output stays high until a controller pulses the acknowledge input. The status byte is always visible on an output so that a poll can capture it. Bus protocol, command parsing and the lower status registers sit outside this block.

Top module: `stat_srq_core`

## Requirements
- R1: While synchronous reset is high, and on the first clock after it, the status byte, the enable readback and the request output are all zero.
- R2: Inputs sampled on a rising clock edge appear on the status byte after that edge at these fixed positions: bit 0 spare_in[0], bit 1 spare_in[1], bit 2 error queue not empty, bit 3 questionable summary, bit 4 message ready, bit 5 event-status summary, bit 7 operation summary.
- R3: Status byte bit 6 is 1 exactly when some other status bit i is 1 while enable bit i is 1.
- R4: Enable bit 6 has no effect on status bit 6 or on the request output.
- R5: A write of en_wdata with en_wr high takes effect on the next clock edge, and all 8 enable bits are read back unchanged on en_rdata.
- R6: When an enabled status bit (not bit 6) changes from 0 to 1 on the status byte, srq is high after the following clock edge.
- R7: A status bit that rises while its enable bit is 0, or an enable write for a bit that is already 1, does not raise srq.
- R8: Once high, srq stays high until srq_ack is sampled high, and it is low after that edge when no new rise is pending.
- R9: If a new enabled rise and srq_ack happen in the same cycle, srq stays high.
- R10: An enabled bit that stays high does not raise srq again after it has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spare_in | input | 2 | Spare status inputs for bits 1:0 |
| errq_nonempty | input | 1 | Error queue holds at least one entry |
| ques_summary | input | 1 | Questionable-status summary |
| msg_ready | input | 1 | Output message waiting to be read |
| evt_summary | input | 1 | Event-status summary |
| oper_summary | input | 1 | Operation-status summary |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write data |
| en_rdata | output | 8 | Enable mask readback |
| status_byte | output | 8 | Status byte including master summary in bit 6 |
| srq_ack | input | 1 | Clears the service request |
| srq | output | 1 | Sticky service request |

## Verification
The bench sets enable bit 6 alone with every input high. A design that did not mask that bit would report a master summary and raise a request from nothing. It enables a bit that is already set; a design that detected rises on the masked vector and not on the raw byte would raise a false request there. It pulses the acknowledge in the same cycle a new rise is detected, which catches a design that lets the clear win and loses the event. It also holds an enabled input high across an acknowledge, which shows up a design that detects levels and not edges, because that design would raise the request again and again.

// File: rtl/stat_srq_pkg.sv
package stat_srq_pkg;
   localparam int STB_W    = 8;
   localparam int SPARE_W  = 2;
   localparam int POS_ERRQ = 2;
   localparam int POS_QUES = 3;
   localparam int POS_MAV  = 4;
   localparam int POS_ESUM = 5;
   localparam int POS_MSS  = 6;
   localparam int POS_OPER = 7;

   typedef logic [STB_W-1:0] stb_t;

   // Build the raw status vector; the master-summary slot is left at zero.
   function automatic stb_t pack_status(input logic [SPARE_W-1:0] spare,
                                        input logic errq, input logic ques,
                                        input logic mav,  input logic esum,
                                        input logic oper);
      stb_t v;
      v = '0;
      v[SPARE_W-1:0] = spare;
      v[POS_ERRQ]    = errq;
      v[POS_QUES]    = ques;
      v[POS_MAV]     = mav;
      v[POS_ESUM]    = esum;
      v[POS_OPER]    = oper;
      return v;
   endfunction
endpackage

// File: rtl/stat_srq_capture.sv
module stat_srq_capture #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] raw_in,
   output logic [W-1:0] cur_q,
   output logic [W-1:0] prev_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= raw_in;
         prev_q <= cur_q;
      end
   end

   a_r2_prev_tracks: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> prev_q == $past(cur_q));
endmodule

// File: rtl/stat_srq_enable.sv
module stat_srq_enable #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q
);
   always_ff @(posedge clk) begin
      if (rst)     en_q <= '0;
      else if (wr) en_q <= wdata;
   end

   a_r5_write_next: assert property (@(posedge clk) disable iff (rst)
      wr |=> en_q == $past(wdata));
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(en_q));
endmodule

// File: rtl/stat_srq_summary.sv
module stat_srq_summary #(
   parameter int W       = 8,
   parameter int MSS_POS = 6
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] en,
   output logic         mss,
   output logic         rise_any
);
   logic [W-1:0] lvl_hit;
   logic [W-1:0] edge_hit;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == MSS_POS) begin : g_skip
         assign lvl_hit[i]  = 1'b0;
         assign edge_hit[i] = 1'b0;
      end else begin : g_use
         assign lvl_hit[i]  = cur[i] & en[i];
         assign edge_hit[i] = cur[i] & ~prev[i] & en[i];
      end
   end

   assign mss      = |lvl_hit;
   assign rise_any = |edge_hit;
endmodule

// File: rtl/stat_srq_request.sv
module stat_srq_request #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rise_any,
   input  logic ack,
   output logic srq
);
   logic srq_d;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (rise_any) srq_d = 1'b1;
         else if (ack) srq_d = 1'b0;
         else          srq_d = srq;
      end
   end else begin : g_clr_first
      always_comb begin
         if (ack)           srq_d = 1'b0;
         else if (rise_any) srq_d = 1'b1;
         else               srq_d = srq;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) srq <= 1'b0;
      else     srq <= srq_d;
   end

   a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      srq && !ack |=> srq);
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
      ack && !rise_any |=> !srq);
   a_r6_rise_sets: assert property (@(posedge clk) disable iff (rst)
      rise_any && (!ack || SET_WINS) |=> srq);
endmodule

// File: rtl/stat_srq_core.sv
module stat_srq_core
   import stat_srq_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [SPARE_W-1:0] spare_in,
   input  logic               errq_nonempty,
   input  logic               ques_summary,
   input  logic               msg_ready,
   input  logic               evt_summary,
   input  logic               oper_summary,
   input  logic               en_wr,
   input  logic [STB_W-1:0]   en_wdata,
   output logic [STB_W-1:0]   en_rdata,
   output logic [STB_W-1:0]   status_byte,
   input  logic               srq_ack,
   output logic               srq
);
   localparam stb_t NOT_MSS = ~(stb_t'(1) << POS_MSS);

   if (POS_MSS >= STB_W || SPARE_W > POS_ERRQ) begin : g_bad_layout
      $error("status byte layout parameters out of range");
   end

   stb_t raw_vec, cur_q, prev_q, en_q;
   logic mss, rise_any;

   assign raw_vec = pack_status(spare_in, errq_nonempty, ques_summary,
                                msg_ready, evt_summary, oper_summary);

   stat_srq_capture #(.W(STB_W)) u_cap (
      .clk(clk), .rst(rst), .raw_in(raw_vec), .cur_q(cur_q), .prev_q(prev_q));

   stat_srq_enable #(.W(STB_W)) u_en (
      .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata), .en_q(en_q));

   stat_srq_summary #(.W(STB_W), .MSS_POS(POS_MSS)) u_sum (
      .cur(cur_q), .prev(prev_q), .en(en_q), .mss(mss), .rise_any(rise_any));

   stat_srq_request #(.SET_WINS(SET_WINS)) u_req (
      .clk(clk), .rst(rst), .rise_any(rise_any), .ack(srq_ack), .srq(srq));

   always_comb begin
      status_byte          = cur_q;
      status_byte[POS_MSS] = mss;
   end
   assign en_rdata = en_q;

   a_r3_mss_justified: assert property (@(posedge clk) disable iff (rst)
      status_byte[POS_MSS] |-> (status_byte & en_rdata & NOT_MSS) != '0);
   a_r4_bit6_blind: assert property (@(posedge clk) disable iff (rst)
      (status_byte & en_rdata & NOT_MSS) != '0 |-> status_byte[POS_MSS]);
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
      $rose(srq) |-> $past(rise_any));
endmodule

// File: tb/sim_stat_srq_core.sv
`timescale 1ns/1ps
module sim_stat_srq_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] spare_in = '0;
   logic       errq = 0, ques = 0, mav = 0, esum = 0, oper = 0;
   logic       en_wr = 0, srq_ack = 0;
   logic [7:0] en_wdata = '0;
   logic [7:0] en_rdata, status_byte;
   logic       srq;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference state
   bit [7:0] m_stb = 0, m_prev = 0, m_en = 0;
   bit       m_srq = 0;

   always #4 clk = ~clk;

   stat_srq_core u0 (
      .clk(clk), .rst(rst), .spare_in(spare_in), .errq_nonempty(errq),
      .ques_summary(ques), .msg_ready(mav), .evt_summary(esum),
      .oper_summary(oper), .en_wr(en_wr), .en_wdata(en_wdata),
      .en_rdata(en_rdata), .status_byte(status_byte), .srq_ack(srq_ack),
      .srq(srq));

   function automatic bit [7:0] sample_raw();
      return {oper, 1'b0, esum, mav, ques, errq, spare_in};
   endfunction

   always @(posedge clk) begin
      bit [7:0] nxt, rise;
      nxt  = sample_raw();
      rise = m_stb & ~m_prev & m_en & 8'hBF;
      if (rst) begin
         m_stb = 0; m_prev = 0; m_en = 0; m_srq = 0;
      end else begin
         if (rise != 0)    m_srq = 1;
         else if (srq_ack) m_srq = 0;
         m_prev = m_stb;
         m_stb  = nxt;
         if (en_wr) m_en = en_wdata;
      end
   end

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         bit [7:0] exp_byte;
         exp_byte    = m_stb;
         exp_byte[6] = |(m_stb & m_en & 8'hBF);
         check("status_byte", status_byte, exp_byte);
         check("en_rdata", en_rdata, m_en);
         check("srq", srq, m_srq);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_en(input bit [7:0] v);
      @(negedge clk); en_wr = 1; en_wdata = v;
      @(negedge clk); en_wr = 0;
   endtask

   task automatic ack();
      @(negedge clk); srq_ack = 1;
      @(negedge clk); srq_ack = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset clears everything even with inputs high
      cur_req = "R1";
      errq = 1; oper = 1;
      cyc(3);
      rst = 0;
      @(posedge clk); #3;
      check("R1 srq after reset", srq, 0);
      check("R1 enable after reset", en_rdata, 0);
      @(negedge clk); errq = 0; oper = 0;
      cyc(3);

      // R2: each input in its own position, nothing enabled
      cur_req = "R2";
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         {oper, esum, mav, ques, errq, spare_in} = 7'(1 << i);
         cyc(2);
      end
      @(negedge clk); {oper, esum, mav, ques, errq, spare_in} = '0;
      cyc(2);

      // R5: enable write and readback, all bits
      cur_req = "R5";
      wr_en(8'hA5); cyc(1);
      wr_en(8'h5A); cyc(1);
      wr_en(8'h00); cyc(1);

      // R3 / R6: enabled error bit raises summary and request
      cur_req = "R6";
      wr_en(8'h04);
      @(negedge clk); errq = 1;
      cyc(3);
      check("R6 srq after rise", srq, 1);
      cur_req = "R3";
      check("R3 mss set", status_byte[6], 1);

      // R8: sticky then acknowledged
      cur_req = "R8";
      cyc(4);
      check("R8 still held", srq, 1);
      ack();
      cyc(1);
      check("R8 cleared", srq, 0);

      // R10: level stays high, no re-trigger
      cur_req = "R10";
      cyc(5);
      check("R10 no retrigger", srq, 0);

      // R7: rise while disabled, then enable already-set bit
      cur_req = "R7";
      @(negedge clk); ques = 1;
      cyc(3);
      wr_en(8'h0C);
      cyc(3);
      check("R7 no srq on late enable", srq, 0);
      check("R7 mss from late enable", status_byte[6], 1);

      // R4: only bit 6 enabled, inputs toggling
      cur_req = "R4";
      wr_en(8'h40);
      @(negedge clk); {oper, esum, mav, ques, errq, spare_in} = '0;
      cyc(2);
      @(negedge clk); {oper, esum, mav, ques, errq, spare_in} = '1;
      cyc(3);
      check("R4 mss ignores enable bit 6", status_byte[6], 0);
      check("R4 no srq", srq, 0);
      @(negedge clk); {oper, esum, mav, ques, errq, spare_in} = '0;
      cyc(2);

      // R9: new rise coincides with acknowledge
      cur_req = "R9";
      wr_en(8'h81);
      @(negedge clk); spare_in[0] = 1;
      cyc(3);
      @(negedge clk); oper = 1;
      @(negedge clk); srq_ack = 1;
      @(negedge clk); srq_ack = 0;
      check("R9 set wins", srq, 1);
      cyc(2);

      // mixed traffic against the reference
      cur_req = "R6";
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         {oper, esum, mav, ques, errq, spare_in} = 7'($urandom);
         srq_ack = ($urandom % 4) == 0;
         en_wr   = ($urandom % 8) == 0;
         en_wdata = 8'($urandom);
      end
      @(negedge clk); srq_ack = 0; en_wr = 0;
      cyc(3);
      finish_run();
   end
endmodule